// File: doc/BRIEF.md
# Lane Steering and Deskew Switch

This block sits between three parallel 10-bit data lanes and the decoders that consume them. Each output lane is fed from an input lane picked by the configuration. The picked word can be held back by a whole number of words to cancel skew between lanes. Its bit order can be reversed, and all of its bits can be inverted. A single static configuration word sets all of this. One bit of that word is a master switch: when it is clear, the lanes pass straight through and every other field is ignored.

Data moves as one word per lane per cycle, qualified by a single valid strobe. The output is registered, so it follows the input by one clock cycle. The deskew delay counts accepted words, not clock cycles.

Top module: `lane_steer_switch`

## Requirements
- R1: When configuration bit 0 is clear, output lane k (bits [10k+9:10k]) equals input lane k of the word accepted one cycle earlier, whatever the other configuration bits hold.
- R2: When bit 0 is set, output lane 0 takes its source lane from bits [25:24], lane 1 from bits [27:26] and lane 2 from bits [29:28]. Codes 0, 1 and 2 name input lanes 0, 1 and 2.
- R3: A source code of 3 feeds that output lane a word of all zeros. That word still passes through the delay, the reversal and the inversion.
- R4: When bit 0 is set, a 3-bit skew value s delays that output lane by exactly s accepted words (0 to 7). Lane 0 reads s from bits [14:12], lane 1 from bits [18:16] and lane 2 from bits [22:20].
- R5: outValid equals inValid of the previous cycle. Cycles with inValid low do not advance the delay lines, and outData holds its last value during them.
- R6: When bit 0 is set, bits 8, 9 and 10 reverse the bit order of lanes 0, 1 and 2: output bit i takes word bit 9-i.
- R7: When bit 0 is set, bits 4, 5 and 6 invert every bit of lanes 0, 1 and 2.
- R8: The order of operations is fixed: source selection, then delay, then reversal, then inversion. Selection acts when a word enters the delay line. Reversal and inversion use the configuration in force when the word leaves it.
- R9: Reset clears outData, outValid and every delay-line entry. A delayed lane therefore emits zero words until real data reaches its output.
- R10: A configuration change applies to the next accepted word. It needs no idle cycle or handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Static steering configuration word |
| inValid | input | 1 | Input word strobe |
| inData | input | 30 | Three input lanes; lane k at bits [10k+9:10k] |
| outValid | output | 1 | Output word strobe |
| outData | output | 30 | Three output lanes; lane k at bits [10k+9:10k] |

## Verification
Assertions check several properties on every cycle. The valid strobe lags the input by one cycle, and the outputs hold during idle cycles. Pass-through is exact while the switch is off. An undelayed lane with no other transform copies its chosen source, and a null source gives a constant word. Reset leaves the outputs clear. Deskew by several words, delay lines that stop during gaps, reversal and inversion applied after the delay, and configuration changes while words are in flight can only be shown by the bench's behavioural reference model. The bench compares that model with the outputs on every clock, across directed and random configurations.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  localparam int CFG_W      = 32;
  localparam int SRC_W      = 2;
  localparam int SKEW_W     = 3;
  localparam int ENABLE_BIT = 0;

  // Per-lane strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [SKEW_W-1:0] skew;
    logic              swap;
    logic              invert;
  } laneCtrl_t;

  // Field placement inside the configuration word; the layout holds three lanes.
  function automatic int srcLsb(input int lane);
    return 24 + SRC_W * lane;
  endfunction

  function automatic int skewLsb(input int lane);
    return 12 + 4 * lane;
  endfunction

  function automatic int swapBit(input int lane);
    return 8 + lane;
  endfunction

  function automatic int invertBit(input int lane);
    return 4 + lane;
  endfunction

  function automatic logic [CFG_W-1:0] usedMask(input int lanes);
    logic [CFG_W-1:0] m;
    m = '0;
    m[ENABLE_BIT] = 1'b1;
    for (int k = 0; k < lanes; k++) begin
      for (int b = 0; b < SRC_W; b++)  m[srcLsb(k) + b]  = 1'b1;
      for (int b = 0; b < SKEW_W; b++) m[skewLsb(k) + b] = 1'b1;
      m[swapBit(k)]   = 1'b1;
      m[invertBit(k)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             inValid,
  output laneCtrl_t        laneCtrl [LANES],
  output logic             shiftEn
);

  localparam logic [CFG_W-1:0] USED = usedMask(LANES);

  logic enable;
  logic unusedCfg;

  assign enable    = cfgWord[ENABLE_BIT];
  assign shiftEn   = inValid;
  assign unusedCfg = ^(cfgWord & ~USED);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int SRC_LSB  = srcLsb(k);
    localparam int SKEW_LSB = skewLsb(k);
    localparam int SWAP_IDX = swapBit(k);
    localparam int INV_IDX  = invertBit(k);

    always_comb begin
      if (enable) begin
        laneCtrl[k].src    = cfgWord[SRC_LSB +: SRC_W];
        laneCtrl[k].skew   = cfgWord[SKEW_LSB +: SKEW_W];
        laneCtrl[k].swap   = cfgWord[SWAP_IDX];
        laneCtrl[k].invert = cfgWord[INV_IDX];
      end else begin
        // Neutral mapping: own lane, no delay, no transform.
        laneCtrl[k].src    = SRC_W'(k);
        laneCtrl[k].skew   = '0;
        laneCtrl[k].swap   = 1'b0;
        laneCtrl[k].invert = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lane_steer_datapath.sv
module lane_steer_datapath
  import lane_steer_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int WORD_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    shiftEn,
  input  laneCtrl_t               laneCtrl [LANES],
  input  logic [LANES*WORD_W-1:0] inWords,
  output logic [LANES*WORD_W-1:0] outWords,
  output logic                    outValid
);

  localparam int HIST_D = (1 << SKEW_W) - 1;

  logic [WORD_W-1:0] inLane [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_in
    assign inLane[j] = inWords[j*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= shiftEn;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WORD_W-1:0] picked;
    logic [WORD_W-1:0] delayed;
    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] finalWord;
    logic [WORD_W-1:0] outReg;
    logic [WORD_W-1:0] hist [HIST_D];

    // Source select; out-of-range codes yield a null word.
    always_comb begin
      picked = '0;
      for (int j = 0; j < LANES; j++) begin
        if (int'(laneCtrl[k].src) == j) picked = inLane[j];
      end
    end

    always_comb begin
      if (laneCtrl[k].skew == '0) delayed = picked;
      else                        delayed = hist[laneCtrl[k].skew - 1'b1];
    end

    always_comb begin
      for (int b = 0; b < WORD_W; b++) begin
        swapped[b] = laneCtrl[k].swap ? delayed[WORD_W-1-b] : delayed[b];
      end
    end

    assign finalWord = swapped ^ {WORD_W{laneCtrl[k].invert}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg <= '0;
        for (int i = 0; i < HIST_D; i++) hist[i] <= '0;
      end else if (shiftEn) begin
        outReg  <= finalWord;
        hist[0] <= picked;
        for (int i = 1; i < HIST_D; i++) hist[i] <= hist[i-1];
      end
    end

    assign outWords[k*WORD_W +: WORD_W] = outReg;

    AST_NULL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(shiftEn) && (int'($past(laneCtrl[k].src)) >= LANES)
        && ($past(laneCtrl[k].skew) == '0))
      |-> (outReg == {WORD_W{$past(laneCtrl[k].invert)}})); // R3

    AST_DIRECT_STEER: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(shiftEn) && (int'($past(laneCtrl[k].src)) < LANES)
        && ($past(laneCtrl[k].skew) == '0) && !$past(laneCtrl[k].swap)
        && !$past(laneCtrl[k].invert))
      |-> (outReg == $past(inLane[laneCtrl[k].src]))); // R2
  end

endmodule

// File: rtl/lane_steer_switch.sv
module lane_steer_switch
  import lane_steer_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int WORD_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CFG_W-1:0]        cfgWord,
  input  logic                    inValid,
  input  logic [LANES*WORD_W-1:0] inData,
  output logic                    outValid,
  output logic [LANES*WORD_W-1:0] outData
);

  laneCtrl_t laneCtrl [LANES];
  logic      shiftEn;

  lane_steer_ctrl #(.LANES(LANES)) u_ctrl (
    .cfgWord  (cfgWord),
    .inValid  (inValid),
    .laneCtrl (laneCtrl),
    .shiftEn  (shiftEn)
  );

  lane_steer_datapath #(.LANES(LANES), .WORD_W(WORD_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .shiftEn  (shiftEn),
    .laneCtrl (laneCtrl),
    .inWords  (inData),
    .outWords (outData),
    .outValid (outValid)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> $stable(outData)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ((outData == '0) && !outValid)); // R9

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(inValid) && !$past(cfgWord[ENABLE_BIT]))
      |-> (outData[k*WORD_W +: WORD_W] == $past(inData[k*WORD_W +: WORD_W]))); // R1
  end

endmodule

// File: tb/lane_steer_switch_test.sv
module lane_steer_switch_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 3;
  localparam int W          = 10;
  localparam int HD         = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        inValid = 1'b0;
  logic [29:0] inData = '0;
  logic        outValid;
  logic [29:0] outData;

  lane_steer_switch uut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  logic [W-1:0] hist [LANES][HD];
  logic [29:0] expData;
  logic        expValid;
  logic [31:0] cfg = '0;
  string       phase = "R9";

  function automatic logic [31:0] mkCfg(input bit en, input int s0, input int s1, input int s2,
                                        input int k0, input int k1, input int k2,
                                        input bit [2:0] sw, input bit [2:0] iv);
    logic [31:0] c;
    c = '0;
    c[0]     = en;
    c[25:24] = 2'(s0); c[27:26] = 2'(s1); c[29:28] = 2'(s2);
    c[14:12] = 3'(k0); c[18:16] = 3'(k1); c[22:20] = 3'(k2);
    for (int i = 0; i < 3; i++) begin
      c[8+i] = sw[i];
      c[4+i] = iv[i];
    end
    return c;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < LANES; k++)
      for (int j = 0; j < HD; j++) hist[k][j] = '0;
    expData  = '0;
    expValid = 1'b0;
  endtask

  task automatic modelStep(input logic v, input logic [29:0] d, input logic [31:0] c);
    if (!v) begin
      expValid = 1'b0;
      return;
    end
    for (int k = 0; k < LANES; k++) begin
      int src, sk;
      bit sw, iv;
      logic [W-1:0] pick, dl, w;
      if (c[0]) begin
        src = int'(c[24+2*k +: 2]); sk = int'(c[12+4*k +: 3]);
        sw = c[8+k]; iv = c[4+k];
      end else begin
        src = k; sk = 0; sw = 1'b0; iv = 1'b0;
      end
      pick = (src < LANES) ? d[src*W +: W] : '0;
      dl = (sk == 0) ? pick : hist[k][sk-1];
      for (int j = HD-1; j > 0; j--) hist[k][j] = hist[k][j-1];
      hist[k][0] = pick;
      w = dl;
      if (sw) for (int b = 0; b < W; b++) w[b] = dl[W-1-b];
      if (iv) w = ~w;
      expData[k*W +: W] = w;
    end
    expValid = 1'b1;
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkNow();
    checks++;
    if (outValid !== expValid || outData !== expData) begin
      failures++;
      $display("FAIL %s actual valid=%0b data=%h expected valid=%0b data=%h",
               phase, outValid, outData, expValid, expData);
    end
  endtask

  task automatic cycle(input logic v, input logic [29:0] d);
    @(negedge clk);
    checkNow();
    inValid = v;
    inData  = d;
    cfgWord = cfg;
    modelStep(v, d, cfg);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    inData = '0;
    modelReset();
    repeat (3) @(negedge clk);
    checkEq("R9 reset outData", 32'(outData), 32'h0);
    checkEq("R9 reset outValid", 32'(outValid), 32'h0);
    rstN = 1'b1;
  endtask

  // Drive one valid word, then look at the lane just after the capturing edge.
  task automatic probe(input string tag, input int lane, input logic [29:0] d, input logic [W-1:0] exp);
    cycle(1'b1, d);
    @(posedge clk);
    #1;
    checkEq(tag, 32'(outData[lane*W +: W]), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();

    // R1: switch off, other fields full of ones
    phase = "R1";
    cfg = 32'hFFFF_FFFE;
    for (int i = 0; i < 20; i++) cycle(1'b1, 30'($urandom));

    // R2: rotated mapping
    phase = "R2";
    cfg = mkCfg(1'b1, 2, 0, 1, 0, 0, 0, 3'b000, 3'b000);
    for (int i = 0; i < 20; i++) cycle(1'b1, 30'($urandom));

    // R3: null source on lane 1, with and without inversion
    phase = "R3";
    cfg = mkCfg(1'b1, 0, 3, 2, 0, 0, 0, 3'b000, 3'b000);
    for (int i = 0; i < 8; i++) cycle(1'b1, 30'($urandom));
    probe("R3 null source lane1", 1, 30'h3FFF_FFFF, 10'h000);
    cfg = mkCfg(1'b1, 0, 3, 2, 0, 0, 0, 3'b000, 3'b010);
    for (int i = 0; i < 8; i++) cycle(1'b1, 30'($urandom));

    // R4: deskew 0 / 3 / 7 with a counting pattern
    phase = "R4";
    cfg = mkCfg(1'b1, 0, 1, 2, 0, 3, 7, 3'b000, 3'b000);
    for (int i = 0; i < 30; i++) cycle(1'b1, {10'(i + 512), 10'(i + 256), 10'(i)});

    // R5: gaps do not advance the delay lines
    phase = "R5";
    for (int i = 0; i < 40; i++) cycle(($urandom % 3) != 0, 30'($urandom));
    cycle(1'b0, '0);

    // R6 / R7: reversal and inversion
    phase = "R6";
    cfg = mkCfg(1'b1, 0, 1, 2, 0, 0, 0, 3'b111, 3'b000);
    probe("R6 reverse lane0", 0, 30'h001, 10'h200);
    for (int i = 0; i < 10; i++) cycle(1'b1, 30'($urandom));
    phase = "R7";
    cfg = mkCfg(1'b1, 0, 1, 2, 0, 0, 0, 3'b000, 3'b001);
    probe("R7 invert lane0", 0, 30'h0F0, 10'h30F);
    for (int i = 0; i < 10; i++) cycle(1'b1, 30'($urandom));

    // R8: transforms change while delayed words are in flight
    phase = "R8";
    cfg = mkCfg(1'b1, 1, 2, 0, 5, 2, 4, 3'b000, 3'b000);
    for (int i = 0; i < 8; i++) cycle(1'b1, 30'($urandom));
    cfg = mkCfg(1'b1, 2, 0, 1, 5, 2, 4, 3'b101, 3'b110);
    for (int i = 0; i < 12; i++) cycle(1'b1, 30'($urandom));

    // R10: new configuration on every word
    phase = "R10";
    for (int i = 0; i < 300; i++) begin
      cfg = $urandom;
      cycle(($urandom % 4) != 0, 30'($urandom));
    end

    // R9: reset mid-run flushes the delay lines
    phase = "R9";
    cfg = mkCfg(1'b1, 0, 1, 2, 7, 7, 7, 3'b000, 3'b000);
    for (int i = 0; i < 10; i++) cycle(1'b1, 30'($urandom));
    doReset();
    probe("R9 flushed lane0", 0, 30'h3FF, 10'h000);
    for (int i = 0; i < 12; i++) cycle(1'b1, 30'($urandom));
    cycle(1'b0, '0);
    cycle(1'b0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule